// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block turns a 16-bit up-counter into waveforms on two compare-output pins, called A and B. A small register write port configures four things: one 2-bit output-action field per pin, a 4-bit waveform mode that selects how the counter counts and where it wraps, two 16-bit compare values and one 16-bit TOP value. Each pin also has a general-purpose port data bit and a direction bit. The block decides, pin by pin, whether the compare logic or the general-purpose port owns the pin. It then drives the pin value and the output enable.

The output-action field means different things in different modes. In the counting modes (free-running and clear-on-compare), a compare match toggles, clears or sets the output. In the fast-PWM modes, the same field selects a non-inverting or inverting waveform. In that case one edge comes from the compare match and the other comes from the counter wrapping to zero. Toggling in fast PWM is only available on pin A, and only in the two modes whose TOP is programmable. The write port is a plain strobe that is accepted on every cycle, so it has no back-pressure. The counter value is brought out so that the pins can be related to it.

Top module: `ocw_unit`

## Requirements
- R1: An output-action field of 00 leaves its pin under port control, so `pin_val` equals `port_dat`. Any field that claims the pin drives `pin_val` from the compare output. Bit 0 of the pin vectors is pin A and bit 1 is pin B.
- R2: `pin_oe` is 1 only when the compare logic owns the pin and that pin's `port_dir` bit is 1. Otherwise `pin_oe` is 0.
- R3: In a non-PWM mode, a field value causes the following action when `count` equals the pin's compare value. The action is visible on the next clock edge.
  - 01 toggles the output.
  - 10 drives the output to 0.
  - 11 drives the output to 1.
- R4: The counter counts up by one on every clock. It wraps to 0 on the edge after it reaches TOP, and in every mode it also wraps after all-ones. TOP depends on the mode:
  - Mode 0, and any mode not listed in R4 or R5: all-ones.
  - Mode 4: compare value A.
  - Mode 12: the TOP register.
- R5: The fast-PWM modes and their TOP values are:
  - Mode 5: 0x00FF.
  - Mode 6: 0x01FF.
  - Mode 7: 0x03FF.
  - Mode 14: the TOP register.
  - Mode 15: compare value A.
- R6: In fast PWM, field 10 is non-inverting. The output becomes 1 on the edge where the counter wraps to 0, and becomes 0 on the edge after a compare match. With compare value C and C at or below TOP, the pin is 1 exactly while `count` is at or below C.
- R7: In fast PWM, field 11 is inverting. The output becomes 0 at the wrap and becomes 1 after a match, so the pin is 0 exactly while `count` is at or below C.
- R8: In fast PWM with field 10 or 11, a compare value equal to TOP gives no match edge. Only the wrap action applies, so the output stays constantly 1 (field 10) or constantly 0 (field 11).
- R9: In modes 14 and 15 with field 01, pin A toggles on each compare match. Pin B with field 01 in these modes is not claimed and stays under port control.
- R10: In fast-PWM modes 5, 6 and 7, field 01 leaves both pins under port control.
- R11: Reset sets all register fields to 0, the counter to 0 and both compare outputs to 0. A compare output keeps its value while its pin is under port control.
- R12: A write with `wr_en` high takes effect on that clock edge. The register addresses are:
  - Address 0: pin A field in [1:0], pin B field in [3:2], mode bits [1:0] in [5:4].
  - Address 1: mode bits [3:2] in [1:0]. This write leaves mode bits [1:0] unchanged.
  - Address 2: compare value A.
  - Address 3: compare value B.
  - Address 4: TOP.
  - Addresses 5 to 7: ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| port_dat | input | 2 | General-purpose port value per pin (bit 0 = A) |
| port_dir | input | 2 | Direction bit per pin, 1 = output |
| pin_val | output | 2 | Value presented to each pin |
| pin_oe | output | 2 | Output driver enable per pin |
| count | output | 16 | Current counter value |

## Verification
Register writes and counter steps land on the clock edge that samples them. A compare-match action appears on the edge after `count` equals the compare value. A wrap action appears on the same edge at which `count` becomes 0. `pin_val` and `pin_oe` follow `port_dat` and `port_dir` in the same cycle without a register. The bench samples every output at the falling edge against a model that it advances one rising edge at a time. That model uses its own copy of the written registers, and any write is applied to the copy only after the prediction for the edge that samples it. In the PWM sweeps, a closed-form duty check (pin level against `count` and the compare value) is armed only after the first wrap that follows the last register write.

// File: rtl/ocw_pkg.sv
package ocw_pkg;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned WAVE_W = 4;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    OUT_OFF = 2'd0,
    OUT_TOG = 2'd1,
    OUT_CLR = 2'd2,
    OUT_SET = 2'd3
  } out_mode_e;

  typedef logic [WAVE_W-1:0] wave_t;

  localparam wave_t WV_FREE    = 4'd0;
  localparam wave_t WV_CTC_CMP = 4'd4;
  localparam wave_t WV_PWM_8   = 4'd5;
  localparam wave_t WV_PWM_9   = 4'd6;
  localparam wave_t WV_PWM_10  = 4'd7;
  localparam wave_t WV_CTC_TOP = 4'd12;
  localparam wave_t WV_PWM_TOP = 4'd14;
  localparam wave_t WV_PWM_CMP = 4'd15;

  localparam logic [ADDR_W-1:0] RA_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] RA_WAVE_HI = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CMP_A   = 3'd2;
  localparam logic [ADDR_W-1:0] RA_CMP_B   = 3'd3;
  localparam logic [ADDR_W-1:0] RA_TOP     = 3'd4;

  function automatic logic wave_is_pwm(wave_t w);
    return (w == WV_PWM_8) || (w == WV_PWM_9) || (w == WV_PWM_10) ||
           (w == WV_PWM_TOP) || (w == WV_PWM_CMP);
  endfunction

  function automatic logic wave_allows_toggle(wave_t w);
    return (w == WV_PWM_TOP) || (w == WV_PWM_CMP);
  endfunction

endpackage

// File: rtl/ocw_regs.sv
module ocw_regs
  import ocw_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  output out_mode_e           mode_a,
  output out_mode_e           mode_b,
  output wave_t               wave,
  output logic [CNT_W-1:0]    cmp_a,
  output logic [CNT_W-1:0]    cmp_b,
  output logic [CNT_W-1:0]    top_val
);

  localparam int unsigned HALF_W = WAVE_W / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_a  <= OUT_OFF;
      mode_b  <= OUT_OFF;
      wave    <= WV_FREE;
      cmp_a   <= '0;
      cmp_b   <= '0;
      top_val <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        RA_CTRL: begin
          mode_a            <= out_mode_e'(wr_data[1:0]);
          mode_b            <= out_mode_e'(wr_data[3:2]);
          wave[HALF_W-1:0]  <= wr_data[5:4];
        end
        RA_WAVE_HI: wave[WAVE_W-1:HALF_W] <= wr_data[HALF_W-1:0];
        RA_CMP_A:   cmp_a   <= wr_data;
        RA_CMP_B:   cmp_b   <= wr_data;
        RA_TOP:     top_val <= wr_data;
        default: ;
      endcase
    end
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_CTRL) |=> (mode_a == $past(wr_data[1:0]) && mode_b == $past(wr_data[3:2]) && wave[1:0] == $past(wr_data[5:4]))); // R12

  AST_HI_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_WAVE_HI) |=> (wave[1:0] == $past(wave[1:0]))); // R12

  AST_NO_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ($stable(wave) && $stable(cmp_a) && $stable(cmp_b) && $stable(top_val))); // R12

endmodule

// File: rtl/ocw_counter.sv
module ocw_counter
  import ocw_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wave_t            wave,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] top_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] CNT_ONE    = CNT_W'(1);
  localparam logic [CNT_W-1:0] PWM_TOP_8  = CNT_W'((1 << 8) - 1);
  localparam logic [CNT_W-1:0] PWM_TOP_9  = CNT_W'((1 << 9) - 1);
  localparam logic [CNT_W-1:0] PWM_TOP_10 = CNT_W'((1 << 10) - 1);

  logic [CNT_W-1:0] top_eff;

  always_comb begin
    case (wave)
      WV_CTC_CMP, WV_PWM_CMP: top_eff = cmp_a;
      WV_CTC_TOP, WV_PWM_TOP: top_eff = top_val;
      WV_PWM_8:               top_eff = PWM_TOP_8;
      WV_PWM_9:               top_eff = PWM_TOP_9;
      WV_PWM_10:              top_eff = PWM_TOP_10;
      default:                top_eff = CNT_MAX;
    endcase
  end

  assign wrap = (cnt == top_eff) || (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + CNT_ONE;
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R4

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrap) |=> (cnt == $past(cnt) + CNT_ONE)); // R4

  AST_PWM8_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (wave == WV_PWM_8 && cnt == PWM_TOP_8) |=> (cnt == '0)); // R5

endmodule

// File: rtl/ocw_channel.sv
module ocw_channel
  import ocw_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter bit          IS_A  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  out_mode_e        mode,
  input  wave_t            wave,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  input  logic             port_dat,
  input  logic             port_dir,
  output logic             pin_val,
  output logic             pin_oe
);

  logic pwm;
  logic tog_ok;
  logic owns;
  logic match;
  logic oc_q;
  logic oc_d;

  assign pwm    = wave_is_pwm(wave);
  assign tog_ok = IS_A && wave_allows_toggle(wave);
  assign owns   = (mode != OUT_OFF) && !(pwm && mode == OUT_TOG && !tog_ok);
  assign match  = (cnt == cmp);

  always_comb begin
    oc_d = oc_q;
    if (owns) begin
      if (!pwm) begin
        case (mode)
          OUT_TOG: if (match) oc_d = ~oc_q;
          OUT_CLR: if (match) oc_d = 1'b0;
          OUT_SET: if (match) oc_d = 1'b1;
          default: ;
        endcase
      end else begin
        case (mode)
          OUT_TOG: if (match) oc_d = ~oc_q;
          OUT_CLR: begin
            if (wrap)       oc_d = 1'b1;
            else if (match) oc_d = 1'b0;
          end
          OUT_SET: begin
            if (wrap)       oc_d = 1'b0;
            else if (match) oc_d = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oc_q <= 1'b0;
    else        oc_q <= oc_d;
  end

  assign pin_val = owns ? oc_q : port_dat;
  assign pin_oe  = owns && port_dir;

  AST_PORT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == OUT_OFF) |-> (pin_val == port_dat && !pin_oe)); // R1

  AST_OE_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_dir) |-> (!pin_oe)); // R2

  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && mode == OUT_CLR && match) |=> (!oc_q)); // R3

  AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm && mode == OUT_SET && match) |=> (oc_q)); // R3

  AST_NONINV_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && mode == OUT_CLR && wrap) |=> (oc_q)); // R6

  AST_INV_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && mode == OUT_SET && wrap) |=> (!oc_q)); // R7

  AST_HOLD_WHEN_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (!owns) |=> (oc_q == $past(oc_q))); // R11

  if (IS_A) begin : g_a_chk
    AST_A_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_allows_toggle(wave) && mode == OUT_TOG && match) |=> (oc_q != $past(oc_q))); // R9
  end else begin : g_b_chk
    AST_B_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_allows_toggle(wave) && mode == OUT_TOG) |-> (pin_val == port_dat && !pin_oe)); // R9
  end

  AST_PWM_TOG_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !wave_allows_toggle(wave) && mode == OUT_TOG) |-> (!pin_oe)); // R10

endmodule

// File: rtl/ocw_unit.sv
module ocw_unit
  import ocw_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  input  logic [NUM_CH-1:0]   port_dat,
  input  logic [NUM_CH-1:0]   port_dir,
  output logic [NUM_CH-1:0]   pin_val,
  output logic [NUM_CH-1:0]   pin_oe,
  output logic [CNT_W-1:0]    count
);

  out_mode_e        mode_a;
  out_mode_e        mode_b;
  wave_t            wave;
  logic [CNT_W-1:0] cmp_a;
  logic [CNT_W-1:0] cmp_b;
  logic [CNT_W-1:0] top_val;
  logic             wrap;

  out_mode_e        ch_mode [NUM_CH];
  logic [CNT_W-1:0] ch_cmp  [NUM_CH];

  ocw_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .mode_a  (mode_a),
    .mode_b  (mode_b),
    .wave    (wave),
    .cmp_a   (cmp_a),
    .cmp_b   (cmp_b),
    .top_val (top_val)
  );

  ocw_counter #(.CNT_W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .wave    (wave),
    .cmp_a   (cmp_a),
    .top_val (top_val),
    .cnt     (count),
    .wrap    (wrap)
  );

  assign ch_mode[0] = mode_a;
  assign ch_mode[1] = mode_b;
  assign ch_cmp[0]  = cmp_a;
  assign ch_cmp[1]  = cmp_b;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ocw_channel #(.CNT_W(CNT_W), .IS_A(g == 0)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (ch_mode[g]),
      .wave     (wave),
      .cmp      (ch_cmp[g]),
      .cnt      (count),
      .wrap     (wrap),
      .port_dat (port_dat[g]),
      .port_dir (port_dir[g]),
      .pin_val  (pin_val[g]),
      .pin_oe   (pin_oe[g])
    );
  end

endmodule

// File: tb/test_ocw_unit.sv
module test_ocw_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  drv_dat = '0;
  logic [1:0]  drv_dir = '0;
  logic [1:0]  port_dat;
  logic [1:0]  port_dir;
  logic [1:0]  pin_val;
  logic [1:0]  pin_oe;
  logic [15:0] count;

  always #10 clk = ~clk;

  assign port_dat = drv_dat;
  assign port_dir = drv_dir;

  ocw_unit i_ocw_unit (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .port_dat (port_dat),
    .port_dir (port_dir),
    .pin_val  (pin_val),
    .pin_oe   (pin_oe),
    .count    (count)
  );

  int    nvec = 0;
  int    nfail = 0;
  bit    done = 1'b0;
  string cur_req = "R11";

  logic [1:0]  s_mode [2];
  logic [3:0]  s_wave;
  logic [15:0] s_cmp [2];
  logic [15:0] s_top;
  logic [15:0] e_cnt;
  logic        e_oc [2];

  bit duty_on = 1'b0;
  bit duty_inv = 1'b0;
  bit seen_zero = 1'b0;
  int duty_ch = 0;

  function automatic bit f_pwm();
    return s_wave inside {4'd5, 4'd6, 4'd7, 4'd14, 4'd15};
  endfunction

  function automatic logic [15:0] f_top();
    case (s_wave)
      4'd4, 4'd15:  return s_cmp[0];
      4'd12, 4'd14: return s_top;
      4'd5:         return 16'h00FF;
      4'd6:         return 16'h01FF;
      4'd7:         return 16'h03FF;
      default:      return 16'hFFFF;
    endcase
  endfunction

  function automatic bit f_owns(int ch);
    if (s_mode[ch] == 2'd0) return 1'b0;
    if (f_pwm() && s_mode[ch] == 2'd1) return (ch == 0) && (s_wave inside {4'd14, 4'd15});
    return 1'b1;
  endfunction

  task automatic predict();
    bit wrap;
    wrap = (e_cnt == f_top()) || (e_cnt == 16'hFFFF);
    for (int ch = 0; ch < 2; ch++) begin
      bit m;
      m = (e_cnt == s_cmp[ch]);
      if (f_owns(ch)) begin
        if (!f_pwm()) begin
          case (s_mode[ch])
            2'd1: if (m) e_oc[ch] = ~e_oc[ch];
            2'd2: if (m) e_oc[ch] = 1'b0;
            2'd3: if (m) e_oc[ch] = 1'b1;
            default: ;
          endcase
        end else begin
          case (s_mode[ch])
            2'd1: if (m) e_oc[ch] = ~e_oc[ch];
            2'd2: if (wrap) e_oc[ch] = 1'b1; else if (m) e_oc[ch] = 1'b0;
            2'd3: if (wrap) e_oc[ch] = 1'b0; else if (m) e_oc[ch] = 1'b1;
            default: ;
          endcase
        end
      end
    end
    e_cnt = wrap ? 16'h0000 : e_cnt + 16'h0001;
  endtask

  task automatic check_one(string what, logic [15:0] act, logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_all();
    check_one("count", count, e_cnt);
    for (int ch = 0; ch < 2; ch++) begin
      bit own;
      own = f_owns(ch);
      check_one("pin_oe", {15'd0, pin_oe[ch]}, {15'd0, own & drv_dir[ch]});
      check_one("pin_val", {15'd0, pin_val[ch]}, {15'd0, own ? e_oc[ch] : drv_dat[ch]});
    end
    if (duty_on) begin
      if (count == 16'd0) seen_zero = 1'b1;
      if (seen_zero)
        check_one("duty", {15'd0, pin_val[duty_ch]},
                  {15'd0, (count <= s_cmp[duty_ch]) ^ duty_inv});
    end
  endtask

  task automatic apply_wr(logic [2:0] a, logic [15:0] d);
    case (a)
      3'd0: begin s_mode[0] = d[1:0]; s_mode[1] = d[3:2]; s_wave[1:0] = d[5:4]; end
      3'd1: s_wave[3:2] = d[1:0];
      3'd2: s_cmp[0] = d;
      3'd3: s_cmp[1] = d;
      3'd4: s_top = d;
      default: ;
    endcase
  endtask

  task automatic step(logic we, logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    check_all();
    predict();
    wr_en = we;
    wr_addr = a;
    wr_data = d;
    if (we) apply_wr(a, d);
  endtask

  task automatic run(int n);
    repeat (n) step(1'b0, 3'd0, 16'd0);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    step(1'b1, a, d);
  endtask

  task automatic cfg(logic [3:0] w, logic [1:0] ma, logic [1:0] mb);
    wr(3'd0, {10'd0, w[1:0], mb, ma});
    wr(3'd1, {14'd0, w[3:2]});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    duty_on = 1'b0;
    @(negedge clk);
    @(negedge clk);
    cur_req = "R11";
    check_one("reset count", count, 16'd0);
    check_one("reset pin_oe", {14'd0, pin_oe}, 16'd0);
    check_one("reset pin_val", {14'd0, pin_val}, {14'd0, drv_dat});
    s_mode[0] = 2'd0; s_mode[1] = 2'd0; s_wave = 4'd0;
    s_cmp[0] = 16'd0; s_cmp[1] = 16'd0; s_top = 16'd0;
    e_cnt = 16'd0; e_oc[0] = 1'b0; e_oc[1] = 1'b0;
    rst_n = 1'b1;
    predict();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    // R11 reset state and R1 port fallback with fields at 00
    drv_dat = 2'b10; drv_dir = 2'b11;
    do_reset();
    cur_req = "R1";
    run(20);
    drv_dat = 2'b01;
    run(10);

    // R3 and R4: clear-on-compare mode 4, A toggles, B sets then clears
    do_reset();
    cur_req = "R3";
    wr(3'd2, 16'd12);
    wr(3'd3, 16'd5);
    cfg(4'd4, 2'd1, 2'd3);
    run(100);
    cfg(4'd4, 2'd1, 2'd2);
    run(100);

    // R4: mode 12 takes TOP from the TOP register
    do_reset();
    cur_req = "R4";
    wr(3'd4, 16'd20);
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd20);
    cfg(4'd12, 2'd2, 2'd1);
    run(120);

    // R6 non-inverting sweep on A, R8 with B compare at TOP
    do_reset();
    cur_req = "R6";
    drv_dir = 2'b11;
    wr(3'd4, 16'd15);
    wr(3'd3, 16'd15);
    cfg(4'd14, 2'd2, 2'd2);
    duty_ch = 0; duty_inv = 1'b0;
    for (int v = 0; v <= 17; v++) begin
      wr(3'd2, 16'(v));
      seen_zero = 1'b0;
      duty_on = 1'b1;
      run(34);
    end
    duty_on = 1'b0;
    cur_req = "R8";
    run(40);

    // R7 inverting sweep on B, R8 with A compare equal to TOP in mode 15
    do_reset();
    cur_req = "R7";
    wr(3'd2, 16'd13);
    cfg(4'd15, 2'd3, 2'd3);
    duty_ch = 1; duty_inv = 1'b1;
    for (int v = 0; v <= 14; v++) begin
      wr(3'd3, 16'(v));
      seen_zero = 1'b0;
      duty_on = 1'b1;
      run(30);
    end
    duty_on = 1'b0;
    cur_req = "R8";
    run(40);

    // R9: toggle on A only in modes 14 and 15
    do_reset();
    cur_req = "R9";
    drv_dat = 2'b01; drv_dir = 2'b11;
    wr(3'd4, 16'd17);
    wr(3'd2, 16'd4);
    wr(3'd3, 16'd4);
    cfg(4'd14, 2'd1, 2'd1);
    run(80);
    wr(3'd2, 16'd14);
    cfg(4'd15, 2'd1, 2'd1);
    run(80);

    // R10 and R5: fixed-TOP PWM modes
    do_reset();
    cur_req = "R10";
    drv_dat = 2'b10;
    wr(3'd2, 16'd40);
    wr(3'd3, 16'd90);
    cfg(4'd5, 2'd1, 2'd1);
    run(300);
    cur_req = "R5";
    cfg(4'd6, 2'd2, 2'd3);
    run(1100);
    cfg(4'd7, 2'd3, 2'd2);
    run(2100);

    // R2: driver enable follows direction bits
    do_reset();
    cur_req = "R2";
    wr(3'd4, 16'd15);
    wr(3'd2, 16'd6);
    wr(3'd3, 16'd9);
    cfg(4'd14, 2'd2, 2'd3);
    for (int i = 0; i < 16; i++) begin
      drv_dir = i[1:0];
      drv_dat = i[3:2];
      run(7);
    end

    // R12: high-mode write keeps low bits, unused addresses ignored
    cur_req = "R12";
    wr(3'd1, 16'd0);
    run(40);
    wr(3'd5, 16'hFFFF);
    wr(3'd6, 16'h0003);
    wr(3'd7, 16'h0001);
    run(40);

    // R4: free-running mode 0 through a full wrap, then an unlisted mode
    do_reset();
    cur_req = "R4";
    drv_dir = 2'b11;
    wr(3'd2, 16'h8000);
    wr(3'd3, 16'hFFFF);
    cfg(4'd0, 2'd1, 2'd3);
    run(65600);
    do_reset();
    wr(3'd2, 16'd7);
    cfg(4'd9, 2'd1, 2'd2);
    run(300);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule